// File: doc/BRIEF.md
# Divided Countdown Timer

This block is a count-down timer with a programmable power-of-two clock prescaler. Software controls it through a narrow register port: one write strobe with a register index and 32 bits of write data, and a combinational read-data path chosen by the same index. Four registers are visible: a timer entry that holds the mode, the mask and the interrupt vector; the initial count; the current count, which is read only; and the divide setting.

A write to the initial count starts a new count from the written value. The count drops by one on every prescaler tick. In one-shot mode it stops at zero and expires once. In periodic mode it reloads every initial-count-plus-one ticks. When an expiry occurs and the entry is not masked, the block emits a single-cycle request together with the entry's 8-bit vector. A downstream interrupt controller takes that request as an edge event.

Top module: `countdown_timer`

## Requirements
- R1: After reset the registers read as follows: entry 0x0001_0000 (masked, one-shot, vector 0), initial count 0, current count 0, divide 0. The prescaler runs at divide-by-1, so the first count with an unmasked one-shot entry and initial count N raises its request N+1 clocks after the write.
- R2: A write to the divide register (index 0x3E) keeps only bits 3, 1 and 0. Reading it back returns the written value AND 0xB.
- R3: The divide code is {bit3, bit1, bit0}. The tick period is 2^((code+1) mod 8) clocks, so code 7 ticks every clock. The prescaler restarts on every write to the initial count or to the divide register, and the first tick comes exactly one full period after that write.
- R4: A write to the initial count (index 0x38) loads the current count (index 0x39) with the written value at the write edge. The current count then drops by one per tick.
- R5: In one-shot mode (entry bit 17 = 0) the current count holds at 0. Exactly one expiry occurs, on the tick after the count reaches 0, which is (N+1)·2^shift clocks after the write.
- R6: In periodic mode (entry bit 17 = 1) the tick after the count reaches 0 reloads it with the initial count and causes an expiry. Expiries therefore repeat every (N+1)·2^shift clocks, including N = 0.
- R7: While entry bit 16 (mask) is set, no request is raised. Counting continues. Clearing the mask lets later expiries raise requests again.
- R8: A request is a one-clock pulse on irq_pulse in the clock after the expiry edge. irq_vector carries entry bits 7:0 during that pulse.
- R9: Writes to the current count or to an unmapped index change nothing, and unmapped indices read 0. The entry stores only bits 17, 16 and 7:0.
- R10: A one-shot count started with initial count 0 never raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one write per cycle |
| reg_idx | input | 8 | Register index for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_idx, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector that goes with irq_pulse |

## Verification
The assertions take for granted that reg_we and reg_idx are known and synchronous to clk after reset. They also assume that a load of the initial count takes priority over a tick in the same cycle, and that the prescale shift changes only together with a prescaler restart. The bench changes every input only on falling edges and issues one write per cycle. Between configuration writes it lets each count run out or parks the timer at zero with the entry masked, so no stale one-shot arm or periodic wrap can bleed into the next measurement.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int IDX_W   = 8;
  localparam int SHIFT_W = 3;
  localparam int DIV_W   = 4;
  localparam int VEC_W   = 8;

  localparam logic [IDX_W-1:0] IDX_LVT  = 8'h32;
  localparam logic [IDX_W-1:0] IDX_INIT = 8'h38;
  localparam logic [IDX_W-1:0] IDX_CUR  = 8'h39;
  localparam logic [IDX_W-1:0] IDX_DIV  = 8'h3E;

  localparam int MODE_BIT = 17;
  localparam int MASK_BIT = 16;

  localparam logic [31:0]      ENTRY_KEEP = 32'h0003_00FF;
  localparam logic [31:0]      ENTRY_RST  = 32'h0001_0000;
  localparam logic [DIV_W-1:0] DIV_KEEP   = 4'hB;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } entry_t;

  // divide setting -> prescale shift: code {b3,b1,b0}, shift = code+1 mod 8
  function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] d);
    logic [SHIFT_W-1:0] code;
    code = {d[3], d[1:0]};
    return code + 3'd1;
  endfunction

endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   idx,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [DATA_W-1:0]  cur_cnt,
  output logic [DATA_W-1:0]  rdata,
  output entry_t             entry,
  output logic [DATA_W-1:0]  init_cnt,
  output logic [SHIFT_W-1:0] shift,
  output logic               load_evt,
  output logic               div_evt
);

  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'(ENTRY_KEEP);
  localparam logic [DATA_W-1:0] KEEP_RST  = DATA_W'(ENTRY_RST);

  logic [DATA_W-1:0]  entry_q;
  logic [DATA_W-1:0]  init_q;
  logic [DIV_W-1:0]   div_q;
  logic [SHIFT_W-1:0] shift_q;
  logic               lvt_evt;

  assign lvt_evt  = we && (idx == IDX_LVT);
  assign load_evt = we && (idx == IDX_INIT);
  assign div_evt  = we && (idx == IDX_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= KEEP_RST;
      init_q  <= '0;
      div_q   <= '0;
      shift_q <= '0;
    end else begin
      if (lvt_evt)  entry_q <= wdata & KEEP_MASK;
      if (load_evt) init_q  <= wdata;
      if (div_evt) begin
        div_q   <= wdata[DIV_W-1:0] & DIV_KEEP;
        shift_q <= div_to_shift(wdata[DIV_W-1:0]);
      end
    end
  end

  assign entry    = '{periodic: entry_q[MODE_BIT],
                      masked:   entry_q[MASK_BIT],
                      vector:   entry_q[VEC_W-1:0]};
  assign init_cnt = init_q;
  assign shift    = shift_q;

  always_comb begin
    case (idx)
      IDX_LVT:  rdata = entry_q;
      IDX_INIT: rdata = init_q;
      IDX_CUR:  rdata = cur_cnt;
      IDX_DIV:  rdata = DATA_W'(div_q);
      default:  rdata = '0;
    endcase
  end

  AST_DIV_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    div_evt |=> (div_q == ($past(wdata[DIV_W-1:0]) & DIV_KEEP))); // R2

  AST_INIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(init_q)); // R9

endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale
  import cdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);

  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] presc_q;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] limit;

  assign span  = {{PRE_W{1'b0}}, 1'b1} << shift;
  assign limit = PRE_W'(span - 1'b1);
  assign tick  = (presc_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       presc_q <= '0;
    else if (restart) presc_q <= '0;
    else if (tick)    presc_q <= '0;
    else              presc_q <= presc_q + 1'b1;
  end

  AST_PRESC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    presc_q <= limit); // R3

endmodule

// File: rtl/cdt_core.sv
module cdt_core
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_cnt,
  input  entry_t           entry,
  output logic [CNT_W-1:0] cur_cnt,
  output logic             wrap_evt,
  output logic             irq,
  output logic [VEC_W-1:0] irq_vec
);

  logic [CNT_W-1:0] cur_q;
  logic             armed_q;
  logic             at_zero;
  logic             irq_q;
  logic [VEC_W-1:0] vec_q;

  assign at_zero  = (cur_q == '0);
  assign wrap_evt = tick && !load && at_zero && (entry.periodic || armed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      armed_q <= 1'b0;
    end else if (load) begin
      cur_q   <= load_val;
      armed_q <= (load_val != '0);
    end else if (tick) begin
      if (!at_zero) begin
        cur_q <= cur_q - 1'b1;
      end else if (entry.periodic) begin
        cur_q <= init_cnt;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      vec_q <= '0;
    end else begin
      irq_q <= wrap_evt && !entry.masked;
      if (wrap_evt) vec_q <= entry.vector;
    end
  end

  assign cur_cnt = cur_q;
  assign irq     = irq_q;
  assign irq_vec = vec_q;

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_q == $past(load_val))); // R4

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !at_zero) |=> (cur_q == $past(cur_q) - 1'b1)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cur_q)); // R3

  AST_ONESHOT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !entry.periodic && !load) |=> (cur_q == '0)); // R5

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && at_zero && entry.periodic) |=> (cur_q == $past(init_cnt))); // R6

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> !$past(entry.masked)); // R7

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (vec_q == $past(entry.vector))); // R8

endmodule

// File: rtl/countdown_timer.sv
module countdown_timer
  import cdt_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [7:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pulse,
  output logic [7:0]        irq_vector
);

  entry_t             entry;
  logic [DATA_W-1:0]  init_cnt;
  logic [DATA_W-1:0]  cur_cnt;
  logic [SHIFT_W-1:0] shift;
  logic               load_evt;
  logic               div_evt;
  logic               restart;
  logic               tick;
  logic               wrap_evt;

  assign restart = load_evt || div_evt;

  cdt_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .idx      (reg_idx),
    .wdata    (reg_wdata),
    .cur_cnt  (cur_cnt),
    .rdata    (reg_rdata),
    .entry    (entry),
    .init_cnt (init_cnt),
    .shift    (shift),
    .load_evt (load_evt),
    .div_evt  (div_evt)
  );

  cdt_prescale u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .shift   (shift),
    .tick    (tick)
  );

  cdt_core #(.CNT_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (load_evt),
    .load_val (reg_wdata),
    .init_cnt (init_cnt),
    .entry    (entry),
    .cur_cnt  (cur_cnt),
    .wrap_evt (wrap_evt),
    .irq      (irq_pulse),
    .irq_vec  (irq_vector)
  );

  AST_IRQ_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(wrap_evt)); // R8

  AST_WRAP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> tick); // R3

endmodule

// File: tb/sim_countdown_timer.sv
`timescale 1ns/1ps
module sim_countdown_timer;
  import cdt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_idx = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  wire  [31:0] reg_rdata;
  wire         irq_pulse;
  wire  [7:0]  irq_vector;

  always #4 clk = ~clk;

  countdown_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pulse(irq_pulse), .irq_vector(irq_vector)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic wr(input logic [7:0] i, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_idx = i; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] i, output logic [31:0] d);
    @(negedge clk);
    reg_idx = i;
    #1;
    d = reg_rdata;
  endtask

  // cycles from the write-return point until irq_pulse seen; -1 if none
  task automatic wait_irq(input int limit, output int c);
    c = 0;
    while (1) begin
      @(negedge clk);
      c++;
      if (irq_pulse) return;
      if (c >= limit) begin c = -1; return; end
    end
  endtask

  function automatic logic [31:0] div_bits(input int code);
    return 32'(((code >> 2) & 1) << 3) | 32'(code & 3);
  endfunction

  initial begin
    logic [31:0] d;
    int c;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(IDX_LVT, d);  chk("R1 entry after reset", d, 32'h0001_0000);
    rd(IDX_INIT, d); chk("R1 init after reset", d, 0);
    rd(IDX_CUR, d);  chk("R1 cur after reset", d, 0);
    rd(IDX_DIV, d);  chk("R1 div after reset", d, 0);
    chk("R1 no irq after reset", irq_pulse, 0);
    wr(IDX_LVT, 32'h12);
    wr(IDX_INIT, 2);
    wait_irq(20, c);
    chk("R1 divide-by-1 after reset", c, 3);
    wr(IDX_LVT, 32'h10000);

    // R2 divide storage
    wr(IDX_DIV, 32'hFFFF_FFFF); rd(IDX_DIV, d); chk("R2 div keeps 0xB", d, 32'hB);
    wr(IDX_DIV, 32'h0000_0004); rd(IDX_DIV, d); chk("R2 div drops bit2", d, 0);

    // R3 / R5 / R8 sweep of every divide code, one-shot
    for (int code = 0; code < 8; code++) begin
      int p, t;
      p = 1 << ((code + 1) % 8);
      t = 4 * p;
      wr(IDX_DIV, div_bits(code) | 32'h4);
      wr(IDX_LVT, 32'h40 + code);
      wr(IDX_INIT, 3);
      wait_irq(t + 5, c);
      chk($sformatf("R3 expiry time code %0d", code), c, t);
      chk($sformatf("R8 vector code %0d", code), irq_vector, 32'h40 + code);
      @(negedge clk);
      chk($sformatf("R8 pulse width code %0d", code), irq_pulse, 0);
      wait_irq(2 * t, c);
      chk($sformatf("R5 single expiry code %0d", code), c, -1);
      reg_idx = IDX_CUR; #1;
      chk($sformatf("R5 count floor code %0d", code), reg_rdata, 0);
    end

    // R4 countdown trace, divide by 4, masked
    wr(IDX_LVT, 32'h10000);
    wr(IDX_DIV, div_bits(1));
    wr(IDX_INIT, 10);
    begin
      int bad = 0;
      int seen = 0;
      reg_idx = IDX_CUR;
      for (int k = 0; k < 48; k++) begin
        int e;
        if (k > 0) @(negedge clk);
        #1;
        e = (k / 4 >= 10) ? 0 : 10 - k / 4;
        if (reg_rdata != 32'(e)) bad++;
        if (irq_pulse) seen++;
      end
      chk("R4 countdown trace mismatches", bad, 0);
      chk("R7 masked one-shot silent", seen, 0);
    end

    // R6 periodic sweep
    for (int ci = 0; ci < 3; ci++) begin
      for (int ni = 0; ni < 3; ni++) begin
        int code, p, n, t, bad, cnt, badcur;
        code = (ci == 0) ? 7 : ci - 1;
        p = 1 << ((code + 1) % 8);
        n = (ni == 0) ? 0 : ((ni == 1) ? 2 : 5);
        t = (n + 1) * p;
        bad = 0; cnt = 0; badcur = 0;
        wr(IDX_DIV, div_bits(code));
        wr(IDX_LVT, 32'h20080);
        wr(IDX_INIT, 32'(n));
        reg_idx = IDX_CUR;
        for (int k = 1; k <= 3 * t; k++) begin
          @(negedge clk);
          #1;
          if (irq_pulse !== (k % t == 0)) bad++;
          if (irq_pulse) cnt++;
          if (k % t == 0 && reg_rdata != 32'(n)) badcur++;
        end
        chk($sformatf("R6 periodic timing p=%0d n=%0d", p, n), bad, 0);
        chk($sformatf("R6 periodic count p=%0d n=%0d", p, n), cnt, 3);
        chk($sformatf("R6 reload value p=%0d n=%0d", p, n), badcur, 0);
        wr(IDX_LVT, 32'h10000);
        wr(IDX_INIT, 0);
      end
    end

    // R7 mask then unmask in periodic mode
    wr(IDX_DIV, 32'hB);
    wr(IDX_LVT, 32'h30011);
    wr(IDX_INIT, 1);
    wait_irq(40, c);
    chk("R7 masked periodic silent", c, -1);
    wr(IDX_LVT, 32'h20011);
    wait_irq(10, c);
    chk("R7 unmask resumes", c > 0, 1);
    chk("R7 vector after unmask", irq_vector, 32'h11);
    wr(IDX_LVT, 32'h10000);
    wr(IDX_INIT, 0);

    // R3 prescaler restart on divide write
    wr(IDX_DIV, div_bits(2));
    wr(IDX_LVT, 32'h22);
    wr(IDX_INIT, 2);
    repeat (4) @(negedge clk);
    wr(IDX_DIV, div_bits(2));
    wait_irq(40, c);
    chk("R3 restart on divide write", c, 24);

    // R10 one-shot with zero count
    wr(IDX_LVT, 32'h10000);
    wr(IDX_INIT, 0);
    wr(IDX_LVT, 32'h33);
    wr(IDX_DIV, 32'hB);
    wr(IDX_INIT, 0);
    wait_irq(50, c);
    chk("R10 zero count silent", c, -1);

    // R9 ignored writes
    wr(IDX_LVT, 32'h10000);
    wr(IDX_CUR, 32'hABCD);
    rd(IDX_CUR, d);  chk("R9 cur write ignored", d, 0);
    rd(IDX_INIT, d); chk("R9 init untouched by cur write", d, 0);
    wr(8'h20, 32'h55);
    rd(8'h20, d);    chk("R9 unmapped reads 0", d, 0);
    rd(IDX_DIV, d);  chk("R9 div untouched", d, 32'hB);
    rd(IDX_LVT, d);  chk("R9 entry untouched", d, 32'h10000);
    wr(IDX_LVT, 32'hFFFF_FFFF);
    rd(IDX_LVT, d);  chk("R9 entry field mask", d, 32'h0003_00FF);
    wr(IDX_LVT, 32'h10000);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule